// File: doc/BRIEF.md
# Early Partial-Address Load Disambiguation

This block sits beside a load/store queue and decides, as early as possible, whether a load can safely start indexing the data cache before its full effective address is known. Stores enter an in-order queue when they are allocated. Each store later delivers the low byte of its address and, some cycles after that, its complete address. A load is presented with the same low byte and with an age tag: the queue tail pointer captured when the load was dispatched. Every store allocated before that tag counts as older than the load.

The partial check compares the load's low byte against every older store that is still queued. It is conservative. A store whose low byte is still unknown, or whose low byte matches, raises a possible conflict. A store with a different low byte is cleared. When no older store conflicts, the load receives an early-go pulse and may begin its cache array read at once. When a conflict is flagged, a dependence level is raised. It stays high until the load's full address has been checked against the flagged stores. That check either withdraws the false flag or confirms a true dependence. A confirmed dependence is held until every matching store has retired.

A single load is tracked at a time through five named states. IDLE waits for a request. PART counts down the partial-check latency. WAIT holds a flagged load until its full address arrives. FULL counts down the full-check latency. HOLD keeps a confirmed dependence until the matching stores retire. The transitions are: IDLE to PART on an accepted request; PART to IDLE with no conflict; PART to WAIT on a conflict when the load's full address is not yet held; PART to FULL on a conflict when it is already held; WAIT to FULL when it arrives; FULL to IDLE on a cleared flag; FULL to HOLD on a confirmed match; HOLD to IDLE when the last matching store retires.

Top module: `early_disambig`

## Requirements
- R1: `st_alloc` while the queue is not full claims the entry at the tail, and `st_alloc_ptr` then advances by one. `st_alloc_ptr` is {wrap bit, index}, with the index in the low log2(DEPTH) bits. After DEPTH outstanding allocations `sq_full` is high, and a further `st_alloc` leaves the pointer unchanged.
- R2: `st_retire` frees the oldest store. `sq_empty` is high when no store is queued, and `st_retire` on an empty queue has no effect.
- R3: A load request accepted on a rising edge (while `ld_busy` is low) produces a one-cycle `ld_part_done` after the third rising edge that follows.
- R4: The partial check flags a conflict (`ld_part_hit` with `ld_part_done`) when any older queued store has an unknown low byte or a low byte equal to `ld_req_part`.
- R5: Stores allocated at or after the load's age tag take no part in either check.
- R6: With no conflict, `ld_early_go` pulses together with `ld_part_done`, `ld_dep` stays low, and `ld_busy` is low in that same cycle.
- R7: A flagged conflict raises `ld_dep` together with `ld_part_done`. `ld_full_we` is accepted while `ld_busy` is high. The full-check result follows the fifth rising edge after the later of two edges: the edge that completes the partial check and the edge that samples `ld_full_we`.
- R8: The full check covers only the flagged stores. If none of them has an unknown full address or one equal to the load's, `ld_clear` pulses, and `ld_dep` and `ld_busy` drop in that same cycle.
- R9: Otherwise `ld_confirm` pulses and `ld_dep` stays high. It drops, and the tracker returns to idle, after the edge that retires the last matching store.
- R10: `ld_req` is ignored while `ld_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_alloc | input | 1 | Allocate a store at the tail |
| st_alloc_ptr | output | IDXW+1 | Tail pointer with wrap bit; also the age tag for loads |
| sq_full | output | 1 | Queue holds DEPTH stores |
| sq_empty | output | 1 | Queue holds no store |
| st_retire | input | 1 | Retire the oldest store |
| st_part_we | input | 1 | Write a store's low address byte |
| st_part_idx | input | IDXW | Entry index for the low byte |
| st_part_addr | input | PW | Low address bits of the store |
| st_full_we | input | 1 | Write a store's full address |
| st_full_idx | input | IDXW | Entry index for the full address |
| st_full_addr | input | AW | Full store address |
| ld_req | input | 1 | Load query request |
| ld_req_age | input | IDXW+1 | Tail pointer sampled at load dispatch |
| ld_req_part | input | PW | Low address bits of the load |
| ld_full_we | input | 1 | Full address of the tracked load is valid |
| ld_full_addr | input | AW | Full load address |
| ld_busy | output | 1 | A load is being tracked |
| ld_part_done | output | 1 | Partial check result is valid this cycle |
| ld_part_hit | output | 1 | Partial check found a possible conflict |
| ld_early_go | output | 1 | Load may start cache indexing early |
| ld_dep | output | 1 | Possible or confirmed dependence is outstanding |
| ld_clear | output | 1 | Full check withdrew the flag |
| ld_confirm | output | 1 | Full check found a true dependence |

## Verification
The assertions assume the following about the inputs. The load age tag lies between the queue head and tail. Store address writes target only allocated entries. A store's entry is never written in the same cycle it is allocated or retired. The directed scenarios respect these limits: they form each age tag from the `st_alloc_ptr` value read at the time, and they write addresses only into entries that were allocated earlier. Within those limits the checks cover the conservative handling of unknown addresses, the rejection of younger stores, and the exact cycles of the partial and full results.

// File: rtl/edis_pkg.sv
package edis_pkg;
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_PART,
        LD_WAIT,
        LD_FULL,
        LD_HOLD
    } ld_state_t;
endpackage

// File: rtl/edis_store_queue.sv
module edis_store_queue #(
    parameter int DEPTH = 8,
    parameter int PW    = 8,
    parameter int AW    = 32,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc,
    input  logic                         retire,
    input  logic                         part_we,
    input  logic [IDXW-1:0]              part_idx,
    input  logic [PW-1:0]                part_addr,
    input  logic                         full_we,
    input  logic [IDXW-1:0]              full_idx,
    input  logic [AW-1:0]                full_addr,
    input  logic [IDXW:0]                age,
    output logic [IDXW:0]                tail_ptr,
    output logic                         q_full,
    output logic                         q_empty,
    output logic [DEPTH-1:0]             older_vec,
    output logic [DEPTH-1:0]             retire_vec,
    output logic [DEPTH-1:0]             pvld_vec,
    output logic [DEPTH-1:0][PW-1:0]     part_arr,
    output logic [DEPTH-1:0]             fvld_vec,
    output logic [DEPTH-1:0][AW-1:0]     full_arr
);
    localparam int PTRW = IDXW + 1;

    logic [PTRW-1:0] head_q, tail_q, count;
    logic [DEPTH-1:0] vld_q;
    logic alloc_ok, retire_ok;

    assign count     = tail_q - head_q;
    assign q_full    = (count == PTRW'(DEPTH));
    assign q_empty   = (count == '0);
    assign alloc_ok  = alloc && !q_full;
    assign retire_ok = retire && !q_empty;
    assign tail_ptr  = tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc_ok)  tail_q <= tail_q + 1'b1;
            if (retire_ok) head_q <= head_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            pvld_vec <= '0;
            fvld_vec <= '0;
            part_arr <= '0;
            full_arr <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retire_ok && head_q[IDXW-1:0] == IDXW'(i)) begin
                    vld_q[i] <= 1'b0;
                end else if (alloc_ok && tail_q[IDXW-1:0] == IDXW'(i)) begin
                    vld_q[i]    <= 1'b1;
                    pvld_vec[i] <= 1'b0;
                    fvld_vec[i] <= 1'b0;
                end
                if (part_we && vld_q[i] && part_idx == IDXW'(i)) begin
                    pvld_vec[i] <= 1'b1;
                    part_arr[i] <= part_addr;
                end
                if (full_we && vld_q[i] && full_idx == IDXW'(i)) begin
                    fvld_vec[i] <= 1'b1;
                    full_arr[i] <= full_addr;
                end
            end
        end
    end

    always_comb begin
        logic [PTRW-1:0] lim;
        logic [IDXW-1:0] rel;
        lim = age - head_q;
        for (int i = 0; i < DEPTH; i++) begin
            rel           = IDXW'(i) - head_q[IDXW-1:0];
            older_vec[i]  = vld_q[i] && ({1'b0, rel} < lim);
            retire_vec[i] = retire_ok && (head_q[IDXW-1:0] == IDXW'(i));
        end
    end
endmodule

// File: rtl/edis_cmp.sv
module edis_cmp #(
    parameter int DEPTH = 8,
    parameter int PW    = 8,
    parameter int AW    = 32
) (
    input  logic [DEPTH-1:0]         pvld_vec,
    input  logic [DEPTH-1:0][PW-1:0] part_arr,
    input  logic [DEPTH-1:0]         fvld_vec,
    input  logic [DEPTH-1:0][AW-1:0] full_arr,
    input  logic [PW-1:0]            ld_part,
    input  logic [AW-1:0]            ld_full,
    output logic [DEPTH-1:0]         part_hit_vec,
    output logic [DEPTH-1:0]         full_hit_vec
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_lane
        assign part_hit_vec[g] = !pvld_vec[g] || (part_arr[g] == ld_part);
        assign full_hit_vec[g] = !fvld_vec[g] || (full_arr[g] == ld_full);
    end
endmodule

// File: rtl/edis_ld_fsm.sv
module edis_ld_fsm
    import edis_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int PW       = 8,
    parameter int AW       = 32,
    parameter int PART_LAT = 3,
    parameter int FULL_LAT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_req,
    input  logic [PW-1:0]    ld_req_part,
    input  logic             ld_full_we,
    input  logic [AW-1:0]    ld_full_addr,
    input  logic [DEPTH-1:0] older_vec,
    input  logic [DEPTH-1:0] retire_vec,
    input  logic [DEPTH-1:0] part_hit_vec,
    input  logic [DEPTH-1:0] full_hit_vec,
    output logic [PW-1:0]    ld_part_q,
    output logic [AW-1:0]    ld_full_q,
    output logic             busy,
    output logic             part_done,
    output logic             part_hit,
    output logic             early_go,
    output logic             dep,
    output logic             clear,
    output logic             confirm
);
    localparam int MAXLAT = (PART_LAT > FULL_LAT) ? PART_LAT : FULL_LAT;
    localparam int CNTW   = $clog2(MAXLAT + 1);

    ld_state_t state_q, nxt;
    logic [CNTW-1:0]  cnt_q;
    logic [DEPTH-1:0] mask_q, live, f_mask;
    logic             full_have_q, full_rdy, p_conf, part_end, full_end;

    assign live     = mask_q & ~retire_vec;
    assign p_conf   = |(live & part_hit_vec);
    assign f_mask   = live & full_hit_vec;
    assign full_rdy = full_have_q || ld_full_we;
    assign part_end = (state_q == LD_PART) && (cnt_q == '0);
    assign full_end = (state_q == LD_FULL) && (cnt_q == '0);
    assign busy     = (state_q != LD_IDLE);

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            LD_IDLE: if (ld_req) nxt = LD_PART;
            LD_PART: if (cnt_q == '0) nxt = p_conf ? (full_rdy ? LD_FULL : LD_WAIT) : LD_IDLE;
            LD_WAIT: if (full_rdy) nxt = LD_FULL;
            LD_FULL: if (cnt_q == '0) nxt = (|f_mask) ? LD_HOLD : LD_IDLE;
            LD_HOLD: if (live == '0) nxt = LD_IDLE;
            default: nxt = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            mask_q      <= '0;
            full_have_q <= 1'b0;
            ld_part_q   <= '0;
            ld_full_q   <= '0;
        end else begin
            if (state_q != nxt) begin
                if (nxt == LD_PART)      cnt_q <= CNTW'(PART_LAT - 1);
                else if (nxt == LD_FULL) cnt_q <= CNTW'(FULL_LAT - 1);
                else                     cnt_q <= '0;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (state_q == LD_IDLE && ld_req)  mask_q <= older_vec & ~retire_vec;
            else if (part_end)                 mask_q <= live & part_hit_vec;
            else if (full_end)                 mask_q <= f_mask;
            else                               mask_q <= live;

            if (state_q == LD_IDLE) begin
                if (ld_req) begin
                    ld_part_q   <= ld_req_part;
                    full_have_q <= 1'b0;
                end
            end else if (ld_full_we) begin
                full_have_q <= 1'b1;
                ld_full_q   <= ld_full_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_done <= 1'b0;
            part_hit  <= 1'b0;
            early_go  <= 1'b0;
            dep       <= 1'b0;
            clear     <= 1'b0;
            confirm   <= 1'b0;
        end else begin
            part_done <= part_end;
            part_hit  <= part_end && p_conf;
            early_go  <= part_end && !p_conf;
            clear     <= full_end && !(|f_mask);
            confirm   <= full_end && (|f_mask);
            if (part_end && p_conf)
                dep <= 1'b1;
            else if ((full_end && !(|f_mask)) || (state_q == LD_HOLD && live == '0))
                dep <= 1'b0;
        end
    end
endmodule

// File: rtl/early_disambig.sv
module early_disambig #(
    parameter int DEPTH    = 8,
    parameter int PW       = 8,
    parameter int AW       = 32,
    parameter int PART_LAT = 3,
    parameter int FULL_LAT = 5,
    parameter int IDXW     = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_alloc,
    output logic [IDXW:0]   st_alloc_ptr,
    output logic            sq_full,
    output logic            sq_empty,
    input  logic            st_retire,
    input  logic            st_part_we,
    input  logic [IDXW-1:0] st_part_idx,
    input  logic [PW-1:0]   st_part_addr,
    input  logic            st_full_we,
    input  logic [IDXW-1:0] st_full_idx,
    input  logic [AW-1:0]   st_full_addr,
    input  logic            ld_req,
    input  logic [IDXW:0]   ld_req_age,
    input  logic [PW-1:0]   ld_req_part,
    input  logic            ld_full_we,
    input  logic [AW-1:0]   ld_full_addr,
    output logic            ld_busy,
    output logic            ld_part_done,
    output logic            ld_part_hit,
    output logic            ld_early_go,
    output logic            ld_dep,
    output logic            ld_clear,
    output logic            ld_confirm
);
    logic [DEPTH-1:0]         older_vec, retire_vec, pvld_vec, fvld_vec;
    logic [DEPTH-1:0]         part_hit_vec, full_hit_vec;
    logic [DEPTH-1:0][PW-1:0] part_arr;
    logic [DEPTH-1:0][AW-1:0] full_arr;
    logic [PW-1:0]            ld_part_q;
    logic [AW-1:0]            ld_full_q;

    edis_store_queue #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .IDXW(IDXW)) u_sq (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (st_alloc),
        .retire     (st_retire),
        .part_we    (st_part_we),
        .part_idx   (st_part_idx),
        .part_addr  (st_part_addr),
        .full_we    (st_full_we),
        .full_idx   (st_full_idx),
        .full_addr  (st_full_addr),
        .age        (ld_req_age),
        .tail_ptr   (st_alloc_ptr),
        .q_full     (sq_full),
        .q_empty    (sq_empty),
        .older_vec  (older_vec),
        .retire_vec (retire_vec),
        .pvld_vec   (pvld_vec),
        .part_arr   (part_arr),
        .fvld_vec   (fvld_vec),
        .full_arr   (full_arr)
    );

    edis_cmp #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_cmp (
        .pvld_vec     (pvld_vec),
        .part_arr     (part_arr),
        .fvld_vec     (fvld_vec),
        .full_arr     (full_arr),
        .ld_part      (ld_part_q),
        .ld_full      (ld_full_q),
        .part_hit_vec (part_hit_vec),
        .full_hit_vec (full_hit_vec)
    );

    edis_ld_fsm #(
        .DEPTH(DEPTH), .PW(PW), .AW(AW), .PART_LAT(PART_LAT), .FULL_LAT(FULL_LAT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_req       (ld_req),
        .ld_req_part  (ld_req_part),
        .ld_full_we   (ld_full_we),
        .ld_full_addr (ld_full_addr),
        .older_vec    (older_vec),
        .retire_vec   (retire_vec),
        .part_hit_vec (part_hit_vec),
        .full_hit_vec (full_hit_vec),
        .ld_part_q    (ld_part_q),
        .ld_full_q    (ld_full_q),
        .busy         (ld_busy),
        .part_done    (ld_part_done),
        .part_hit     (ld_part_hit),
        .early_go     (ld_early_go),
        .dep          (ld_dep),
        .clear        (ld_clear),
        .confirm      (ld_confirm)
    );
endmodule

// File: rtl/edis_checker.sv
module edis_checker #(
    parameter int PTRW     = 4,
    parameter int PART_LAT = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            st_alloc,
    input logic            st_retire,
    input logic [PTRW-1:0] st_alloc_ptr,
    input logic            sq_full,
    input logic            sq_empty,
    input logic            ld_req,
    input logic            ld_busy,
    input logic            ld_part_done,
    input logic            ld_part_hit,
    input logic            ld_early_go,
    input logic            ld_dep,
    input logic            ld_clear,
    input logic            ld_confirm
);
    logic [7:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  since_q <= 8'hff;
        else if (ld_req && !ld_busy) since_q <= 8'd0;
        else if (since_q != 8'hff)   since_q <= since_q + 8'd1;
    end

    a_r1_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        sq_full && st_alloc |=> $stable(st_alloc_ptr));

    a_r2_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sq_full && sq_empty));

    a_r3_part_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ld_part_done |-> (int'(since_q) == PART_LAT));

    a_r6_early_no_dep: assert property (@(posedge clk) disable iff (!rst_n)
        ld_early_go |-> (!ld_dep && !ld_busy && !ld_part_hit));

    a_r7_hit_raises_dep: assert property (@(posedge clk) disable iff (!rst_n)
        ld_part_hit |-> ld_dep);

    a_r8_clear_vs_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_clear && ld_confirm));

    a_r9_dep_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_dep) |-> (ld_clear || $past(st_retire)));

    a_r10_dep_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dep |-> ld_busy);
endmodule

bind early_disambig edis_checker #(.PTRW(IDXW + 1), .PART_LAT(PART_LAT)) u_edis_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_alloc     (st_alloc),
    .st_retire    (st_retire),
    .st_alloc_ptr (st_alloc_ptr),
    .sq_full      (sq_full),
    .sq_empty     (sq_empty),
    .ld_req       (ld_req),
    .ld_busy      (ld_busy),
    .ld_part_done (ld_part_done),
    .ld_part_hit  (ld_part_hit),
    .ld_early_go  (ld_early_go),
    .ld_dep       (ld_dep),
    .ld_clear     (ld_clear),
    .ld_confirm   (ld_confirm)
);

// File: tb/early_disambig_test.sv
`timescale 1ns/1ps
module early_disambig_test;
    localparam int DEPTH = 8;
    localparam int PW    = 8;
    localparam int AW    = 32;
    localparam int IDXW  = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_alloc = 0, st_retire = 0, st_part_we = 0, st_full_we = 0;
    logic [IDXW-1:0] st_part_idx = '0, st_full_idx = '0;
    logic [PW-1:0] st_part_addr = '0, ld_req_part = '0;
    logic [AW-1:0] st_full_addr = '0, ld_full_addr = '0;
    logic ld_req = 0, ld_full_we = 0;
    logic [IDXW:0] ld_req_age = '0;
    logic [IDXW:0] st_alloc_ptr;
    logic sq_full, sq_empty, ld_busy, ld_part_done, ld_part_hit, ld_early_go;
    logic ld_dep, ld_clear, ld_confirm;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    early_disambig #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic alloc_one();
        st_alloc = 1; step(); st_alloc = 0;
    endtask

    task automatic retire_one();
        st_retire = 1; step(); st_retire = 0;
    endtask

    task automatic wpart(input int idx, input logic [PW-1:0] a);
        st_part_we = 1; st_part_idx = IDXW'(idx); st_part_addr = a;
        step(); st_part_we = 0;
    endtask

    task automatic wfull(input int idx, input logic [AW-1:0] a);
        st_full_we = 1; st_full_idx = IDXW'(idx); st_full_addr = a;
        step(); st_full_we = 0;
    endtask

    task automatic load(input int age, input logic [PW-1:0] p);
        ld_req = 1; ld_req_age = (IDXW+1)'(age); ld_req_part = p;
        step(); ld_req = 0;
    endtask

    task automatic t_reset();
        chk("R2 empty after reset", 32'(sq_empty), 1);
        chk("R1 not full after reset", 32'(sq_full), 0);
        chk("R1 pointer after reset", 32'(st_alloc_ptr), 0);
        chk("R10 idle after reset", 32'(ld_busy), 0);
        chk("R7 no dep after reset", 32'(ld_dep), 0);
    endtask

    task automatic t_early();
        for (int i = 0; i < 3; i++) begin
            chk("R1 tail before alloc", 32'(st_alloc_ptr), 32'(i));
            alloc_one();
        end
        chk("R2 not empty", 32'(sq_empty), 0);
        wpart(0, 8'h10);
        wpart(1, 8'h22);
        // store 2 has unknown low byte but is younger than age 2 (R5)
        load(2, 8'h33);
        step(); step();
        chk("R3 done not early", 32'(ld_part_done), 0);
        step();
        chk("R3 done on third edge", 32'(ld_part_done), 1);
        chk("R5 younger unknown store ignored", 32'(ld_part_hit), 0);
        chk("R6 early go", 32'(ld_early_go), 1);
        chk("R6 no dep", 32'(ld_dep), 0);
        chk("R6 idle with result", 32'(ld_busy), 0);
        step();
        chk("R3 done is one cycle", 32'(ld_part_done), 0);
    endtask

    task automatic t_false();
        wpart(2, 8'h44);
        wfull(2, 32'h1000_0044);
        load(3, 8'h44);
        step(); step(); step();
        chk("R4 low byte match flags", 32'(ld_part_hit), 1);
        chk("R4 no early go", 32'(ld_early_go), 0);
        chk("R7 dep with hit", 32'(ld_dep), 1);
        step();
        chk("R7 waits for full address", 32'(ld_busy), 1);
        ld_full_we = 1; ld_full_addr = 32'h2000_0044;
        step(); ld_full_we = 0;
        for (int k = 0; k < 4; k++) step();
        chk("R7 no result before fifth edge", 32'(ld_clear), 0);
        chk("R7 dep held during check", 32'(ld_dep), 1);
        step();
        chk("R8 false flag cleared", 32'(ld_clear), 1);
        chk("R8 not confirmed", 32'(ld_confirm), 0);
        chk("R8 dep dropped", 32'(ld_dep), 0);
        chk("R8 idle", 32'(ld_busy), 0);
    endtask

    task automatic t_true();
        wfull(0, 32'hABCD_0010);
        wfull(1, 32'h0000_0022);
        load(3, 8'h10);
        ld_full_we = 1; ld_full_addr = 32'hABCD_0010;
        step(); ld_full_we = 0;
        step(); step();
        chk("R4 match on store 0", 32'(ld_part_hit), 1);
        for (int k = 0; k < 4; k++) step();
        chk("R7 result not before fifth edge", 32'(ld_confirm), 0);
        step();
        chk("R9 true match confirmed", 32'(ld_confirm), 1);
        chk("R9 not cleared", 32'(ld_clear), 0);
        chk("R9 dep held", 32'(ld_dep), 1);
        ld_req = 1; ld_req_age = 4'd3; ld_req_part = 8'h77;
        step(); ld_req = 0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R10 request ignored while busy", 32'(ld_part_done), 0);
        end
        chk("R9 dep held until retire", 32'(ld_dep), 1);
        retire_one();
        chk("R9 dep drops at retire", 32'(ld_dep), 0);
        chk("R9 idle after retire", 32'(ld_busy), 0);
        for (int k = 0; k < 3; k++) step();
        chk("R10 no late result", 32'(ld_part_done), 0);
    endtask

    task automatic t_capacity();
        for (int i = 0; i < 6; i++) alloc_one();
        chk("R1 full after DEPTH", 32'(sq_full), 1);
        chk("R1 pointer at full", 32'(st_alloc_ptr), 9);
        alloc_one();
        chk("R1 alloc ignored when full", 32'(st_alloc_ptr), 9);
        for (int i = 0; i < 8; i++) retire_one();
        chk("R2 empty after retiring all", 32'(sq_empty), 1);
        retire_one();
        chk("R2 empty retire ignored", 32'(sq_empty), 1);
        alloc_one();
        chk("R1 pointer after refill", 32'(st_alloc_ptr), 10);
        chk("R2 one entry", 32'(sq_empty), 0);
        retire_one();
        chk("R2 head not over-advanced", 32'(sq_empty), 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_early();
        t_false();
        t_true();
        t_capacity();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule